// File: doc/BRIEF.md
# Steepest-Descent Channel Estimate Iterator

This block runs one step of a gradient-descent refinement of a channel estimate matrix. The estimate has ROWS rows and COLS columns of signed 8-bit entries. Each new entry is the old entry minus a scaled error term. The error term is the estimate row multiplied by a COLS×COLS bit-correlation matrix, minus the matching entry of a ROWS×COLS cross-correlation matrix. The step size is a power of two, so the scaling is an arithmetic right shift by SHIFT bits.

The two correlation matrices live outside the block. The block reads them one row per request through read ports with one cycle of latency. The estimate is held inside in two row-wide banks. One bank supplies the old estimate while the other receives the new one, and the roles swap when an iteration completes. Each row is computed with COLS multiply-accumulate lanes in parallel. Each cycle supplies one old-estimate element and one correlation row, so a row takes COLS accumulate cycles plus three overhead cycles.

Each finished row is offered on a valid/ready output stream as it is written. While `out_valid` is high and `out_ready` is low, the beat holds, no buffer write happens and the next row does not begin. The beat is accepted in any cycle in which both are high. `out_ready` may change freely, and `out_valid` never depends on it. Software seeds the estimate through a plain row-write port while the block is idle.

Top module: `cge_iter`

## Requirements
- R1: For output row n and column j: acc = Σ_k A[n][k]·Rbb[k][j]; e = acc − Rbr[n][j]; d = e >>> SHIFT (floor); new = A[n][j] − d. All operands are two's-complement 8-bit values.
- R2: Each new entry saturates to the range −128..127 before it is stored and emitted.
- R3: The products are 16 bits and the sum is kept in a 16-bit two's-complement accumulator that wraps modulo 2^16. The subtraction and shift after it do not wrap.
- R4: An iteration emits exactly ROWS beats, with `out_row` ascending from 0. Element j of a row word sits at bits [8j+7:8j] of `out_data`, `ld_data` and both read-data buses.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_row` and `out_data` stay unchanged in the next cycle.
- R6: `done` is a one-cycle pulse in the cycle after the last beat is accepted, and `busy` is low from then on. With `out_ready` held high, `done` rises ROWS·(COLS+3) clock edges after the edge that samples `start`.
- R7: A row written through the load port while idle is used as the old estimate by the next iteration. The next iteration takes as its old estimate the result of the one before it.
- R8: `start` and `ld_en` have no effect while `busy` is high.
- R9: For each row, the bit-correlation read port requests rows 0..COLS-1 in order, one per cycle. Read data is taken one cycle after the request. The cross-correlation port is read at row n once per output row.
- R10: After reset, `busy`, `done` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one iteration (idle only) |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle completion pulse |
| ld_en | input | 1 | Write one estimate row (idle only) |
| ld_row | input | RW | Row index for the load |
| ld_data | input | COLS*8 | Row word for the load |
| rbb_rd_en | output | 1 | Bit-correlation read request |
| rbb_addr | output | CW | Bit-correlation row index |
| rbb_rdata | input | COLS*8 | Bit-correlation row, one cycle after request |
| rbr_rd_en | output | 1 | Cross-correlation read request |
| rbr_addr | output | RW | Cross-correlation row index |
| rbr_rdata | input | COLS*8 | Cross-correlation row, one cycle after request |
| out_valid | output | 1 | New estimate row available |
| out_ready | input | 1 | Consumer accepts the row |
| out_row | output | RW | Row index of the beat |
| out_data | output | COLS*8 | New estimate row |

## Verification
The bench builds the block with ROWS=3, COLS=4 and SHIFT=3. Four products of full-scale operands then exceed the 16-bit accumulator, which exercises the wrap. A shift of three is small enough that the step can push an entry past both rails, which exercises the saturation. The odd row count and the short rows keep each iteration to a few dozen cycles. That leaves room to run the stream with both constant and irregular back-pressure and to chain several iterations through the swapping banks.

// File: rtl/cge_pkg.sv
package cge_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_MAC   = 3'd2,
    ST_DRAIN = 3'd3,
    ST_WRITE = 3'd4
  } cge_state_t;
endpackage

// File: rtl/cge_mac_lane.sv
// One multiply-accumulate lane: signed W x W product, wrapping ACC_W accumulator.
module cge_mac_lane #(
  parameter int W     = 8,
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  output logic [ACC_W-1:0] acc
);
  logic signed [2*W-1:0]   prod;
  logic signed [ACC_W-1:0] prod_x;

  assign prod   = $signed(a) * $signed(b);
  assign prod_x = ACC_W'(prod);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) acc <= '0;
    else if (en)       acc <= acc + prod_x;
  end
endmodule

// File: rtl/cge_update_lane.sv
// Combinational element update: old - ((acc - br) >>> SHIFT), saturated to W bits.
module cge_update_lane #(
  parameter int W     = 8,
  parameter int ACC_W = 16,
  parameter int SHIFT = 4
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [W-1:0]     br,
  input  logic [W-1:0]     old,
  output logic [W-1:0]     nv
);
  localparam int EW = ACC_W + 1;
  localparam int RW = ACC_W + 2;
  localparam int HI_I = (1 << (W - 1)) - 1;
  localparam logic signed [RW-1:0] HI = RW'(HI_I);
  localparam logic signed [RW-1:0] LO = ~HI;

  logic signed [EW-1:0] err;
  logic signed [EW-1:0] step;
  logic signed [RW-1:0] raw;

  always_comb begin
    err  = $signed({acc[ACC_W-1], acc}) - $signed({{(EW-W){br[W-1]}}, br});
    step = err >>> SHIFT;
    raw  = $signed({{(RW-W){old[W-1]}}, old}) - $signed({step[EW-1], step});
    if (raw > HI)      nv = HI[W-1:0];
    else if (raw < LO) nv = LO[W-1:0];
    else               nv = raw[W-1:0];
  end
endmodule

// File: rtl/cge_pingpong.sv
// Two row-wide banks. The load port fills the bank holding the current estimate;
// the update port fills the other one. A swap exchanges the roles.
module cge_pingpong #(
  parameter int ROWS = 8,
  parameter int RW   = 3,
  parameter int DW   = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          swap,
  input  logic          ld_en,
  input  logic [RW-1:0] ld_row,
  input  logic [DW-1:0] ld_data,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_row,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [RW-1:0] rd_row,
  output logic [DW-1:0] rd_data
);
  logic sel;
  logic rd_sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel      <= 1'b0;
      rd_sel_q <= 1'b0;
    end else begin
      if (swap)  sel      <= ~sel;
      if (rd_en) rd_sel_q <= sel;
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DW-1:0] mem [ROWS];
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (ld_en && (sel == 1'(b)))  mem[ld_row] <= ld_data;
      if (wr_en && (sel != 1'(b)))  mem[wr_row] <= wr_data;
      if (rd_en)                    q <= mem[rd_row];
    end
  end

  assign rd_data = rd_sel_q ? g_bank[1].q : g_bank[0].q;
endmodule

// File: rtl/cge_ctrl.sv
// Row/column sequencer: FETCH, COLS MAC cycles, DRAIN, WRITE (holds for ready).
module cge_ctrl
  import cge_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int RW   = 3,
  parameter int CW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          out_ready,
  output logic          busy,
  output logic          done,
  output logic          fetch,
  output logic          mac_issue,
  output logic          capture,
  output logic          mac_v,
  output logic [CW-1:0] k,
  output logic [CW-1:0] k_d,
  output logic [RW-1:0] row,
  output logic          out_valid,
  output logic          wr_en,
  output logic          swap
);
  localparam logic [CW-1:0] K_LAST   = CW'(COLS - 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);

  cge_state_t st;

  assign busy      = (st != ST_IDLE);
  assign fetch     = (st == ST_FETCH);
  assign mac_issue = (st == ST_MAC);
  assign capture   = (st == ST_MAC) && (k == '0);
  assign out_valid = (st == ST_WRITE);
  assign wr_en     = out_valid && out_ready;
  assign swap      = wr_en && (row == ROW_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      row   <= '0;
      k     <= '0;
      k_d   <= '0;
      mac_v <= 1'b0;
      done  <= 1'b0;
    end else begin
      done  <= 1'b0;
      mac_v <= (st == ST_MAC);
      k_d   <= k;
      case (st)
        ST_IDLE: if (start) begin
          row <= '0;
          st  <= ST_FETCH;
        end
        ST_FETCH: begin
          k  <= '0;
          st <= ST_MAC;
        end
        ST_MAC: begin
          if (k == K_LAST) st <= ST_DRAIN;
          else             k  <= k + 1'b1;
        end
        ST_DRAIN: st <= ST_WRITE;
        ST_WRITE: if (out_ready) begin
          if (row == ROW_LAST) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end else begin
            row <= row + 1'b1;
            st  <= ST_FETCH;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cge_iter.sv
// One steepest-descent iteration over a ROWS x COLS estimate with COLS MAC lanes.
module cge_iter #(
  parameter int ROWS  = 8,
  parameter int COLS  = 8,
  parameter int W     = 8,
  parameter int ACC_W = 16,
  parameter int SHIFT = 4,
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW   = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int DW   = COLS * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  input  logic          ld_en,
  input  logic [RW-1:0] ld_row,
  input  logic [DW-1:0] ld_data,
  output logic          rbb_rd_en,
  output logic [CW-1:0] rbb_addr,
  input  logic [DW-1:0] rbb_rdata,
  output logic          rbr_rd_en,
  output logic [RW-1:0] rbr_addr,
  input  logic [DW-1:0] rbr_rdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [RW-1:0] out_row,
  output logic [DW-1:0] out_data
);
  logic          fetch, mac_issue, capture, mac_v, wr_en, swap;
  logic [CW-1:0] k, k_d;
  logic [RW-1:0] row;
  logic [DW-1:0] old_rd;
  logic [DW-1:0] a_row, br_row;
  logic [W-1:0]  a_elem;
  logic [COLS*ACC_W-1:0] acc_bus;

  cge_ctrl #(.ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .out_ready(out_ready),
    .busy(busy), .done(done), .fetch(fetch), .mac_issue(mac_issue),
    .capture(capture), .mac_v(mac_v), .k(k), .k_d(k_d), .row(row),
    .out_valid(out_valid), .wr_en(wr_en), .swap(swap)
  );

  cge_pingpong #(.ROWS(ROWS), .RW(RW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .swap(swap),
    .ld_en(ld_en && !busy), .ld_row(ld_row), .ld_data(ld_data),
    .wr_en(wr_en), .wr_row(row), .wr_data(out_data),
    .rd_en(fetch), .rd_row(row), .rd_data(old_rd)
  );

  assign rbb_rd_en = mac_issue;
  assign rbb_addr  = k;
  assign rbr_rd_en = fetch;
  assign rbr_addr  = row;
  assign out_row   = row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_row  <= '0;
      br_row <= '0;
    end else if (capture) begin
      a_row  <= old_rd;
      br_row <= rbr_rdata;
    end
  end

  assign a_elem = a_row[k_d*W +: W];

  for (genvar j = 0; j < COLS; j++) begin : g_lane
    cge_mac_lane #(.W(W), .ACC_W(ACC_W)) u_mac (
      .clk(clk), .rst_n(rst_n), .clr(fetch), .en(mac_v),
      .a(a_elem), .b(rbb_rdata[j*W +: W]),
      .acc(acc_bus[j*ACC_W +: ACC_W])
    );
    cge_update_lane #(.W(W), .ACC_W(ACC_W), .SHIFT(SHIFT)) u_upd (
      .acc(acc_bus[j*ACC_W +: ACC_W]), .br(br_row[j*W +: W]),
      .old(a_row[j*W +: W]), .nv(out_data[j*W +: W])
    );
  end
endmodule

// File: rtl/cge_iter_chk.sv
module cge_iter_chk #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int RW   = 3,
  parameter int CW   = 3,
  parameter int DW   = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          rbb_rd_en,
  input logic [CW-1:0] rbb_addr,
  input logic          out_valid,
  input logic          out_ready,
  input logic [RW-1:0] out_row,
  input logic [DW-1:0] out_data
);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_row)));

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(out_valid && out_ready)) |=> busy);

  p_addr_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rbb_rd_en |-> (int'(rbb_addr) < COLS));

  p_row_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_row) < ROWS));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid);
endmodule

bind cge_iter cge_iter_chk #(.ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .rbb_rd_en(rbb_rd_en), .rbb_addr(rbb_addr),
  .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row), .out_data(out_data)
);

// File: tb/sim_cge_iter.sv
module sim_cge_iter;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS  = 3;
  localparam int COLS  = 4;
  localparam int SHIFT = 3;
  localparam int RW    = 2;
  localparam int CW    = 2;
  localparam int DW    = COLS * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ld_en = 1'b0;
  logic [RW-1:0] ld_row = '0;
  logic [DW-1:0] ld_data = '0;
  logic out_ready = 1'b1;
  logic busy, done, rbb_rd_en, rbr_rd_en, out_valid;
  logic [CW-1:0] rbb_addr;
  logic [RW-1:0] rbr_addr, out_row;
  logic [DW-1:0] rbb_rdata, rbr_rdata, out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  cge_iter #(.ROWS(ROWS), .COLS(COLS), .SHIFT(SHIFT)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .ld_en(ld_en), .ld_row(ld_row), .ld_data(ld_data),
    .rbb_rd_en(rbb_rd_en), .rbb_addr(rbb_addr), .rbb_rdata(rbb_rdata),
    .rbr_rd_en(rbr_rd_en), .rbr_addr(rbr_addr), .rbr_rdata(rbr_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row), .out_data(out_data)
  );

  // external correlation memories, one cycle read latency (R9)
  logic [DW-1:0] rbb_m [COLS];
  logic [DW-1:0] rbr_m [ROWS];
  always @(posedge clk) begin
    if (rbb_rd_en) rbb_rdata <= rbb_m[rbb_addr];
    if (rbr_rd_en) rbr_rdata <= rbr_m[rbr_addr];
  end

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int amdl [ROWS][COLS];
  logic [DW-1:0] exp_d [$];
  int exp_r [$];
  string cur_tag = "R1";
  bit rdy_mode = 1'b0;
  bit exp_done = 1'b0;
  bit stalled = 1'b0;
  logic [DW-1:0] prev_d;
  logic [RW-1:0] prev_r;
  int exp_k = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", req, act, expv, $time);
    end
  endtask

  function automatic int el(input logic [DW-1:0] v, input int j);
    logic [7:0] b;
    b = v[j*8 +: 8];
    return int'($signed(b));
  endfunction

  // reference model of one iteration: queue expected rows, advance model estimate
  task automatic plan_iter();
    int nxt [ROWS][COLS];
    for (int n = 0; n < ROWS; n++) begin
      logic [DW-1:0] rw;
      for (int j = 0; j < COLS; j++) begin
        int acc, e, d, nv;
        acc = 0;
        for (int k = 0; k < COLS; k++) acc += amdl[n][k] * el(rbb_m[k], j);
        acc = acc & 32'hFFFF;
        if (acc >= 32768) acc -= 65536;
        e  = acc - el(rbr_m[n], j);
        d  = e >>> SHIFT;
        nv = amdl[n][j] - d;
        if (nv > 127) nv = 127;
        if (nv < -128) nv = -128;
        nxt[n][j] = nv;
        rw[j*8 +: 8] = nv[7:0];
      end
      exp_d.push_back(rw);
      exp_r.push_back(n);
    end
    for (int n = 0; n < ROWS; n++)
      for (int j = 0; j < COLS; j++) amdl[n][j] = nxt[n][j];
  endtask

  task automatic load_row(input int n, input int v0, input int v1, input int v2, input int v3);
    logic [DW-1:0] w;
    int vals [COLS];
    vals = '{v0, v1, v2, v3};
    for (int j = 0; j < COLS; j++) begin
      w[j*8 +: 8] = vals[j][7:0];
      amdl[n][j] = vals[j];
    end
    @(negedge clk);
    ld_en = 1'b1; ld_row = RW'(n); ld_data = w;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (!done) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // per-cycle monitor; also the only driver of out_ready
  always @(negedge clk) begin
    if (rst_n) begin
      out_ready = rdy_mode ? (($urandom % 3) != 0) : 1'b1;
      if (stalled)
        chk(out_valid && out_data == prev_d && out_row == prev_r, "R5", 64'(out_data), 64'(prev_d));
      chk(done == exp_done, "R6", 64'(done), 64'(exp_done));
      exp_done = 1'b0;
      if (rbb_rd_en) begin
        chk(int'(rbb_addr) == exp_k, "R9", 64'(rbb_addr), 64'(exp_k));
        exp_k = (exp_k + 1) % COLS;
      end
      if (out_valid && out_ready) begin
        if (exp_d.size() == 0) begin
          chk(1'b0, "R4", 64'(out_row), 64'hFFFF);
        end else begin
          logic [DW-1:0] ed;
          int er;
          ed = exp_d.pop_front();
          er = exp_r.pop_front();
          chk(int'(out_row) == er, "R4", 64'(out_row), 64'(er));
          chk(out_data == ed, cur_tag, 64'(out_data), 64'(ed));
          if (exp_d.size() == 0) exp_done = 1'b1;
        end
      end
      stalled = out_valid && !out_ready;
      prev_d = out_data;
      prev_r = out_row;
    end
  end

  initial begin
    for (int k = 0; k < COLS; k++)
      for (int j = 0; j < COLS; j++) rbb_m[k][j*8 +: 8] = 8'(((k*5 + j*11) % 31) - 15);
    for (int n = 0; n < ROWS; n++)
      for (int j = 0; j < COLS; j++) rbr_m[n][j*8 +: 8] = 8'(((n*13 + j) % 61) - 30);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !out_valid, "R10", {61'd0, busy, done, out_valid}, 64'd0);

    // iteration 1: loaded estimate, constant ready, exact latency (R1, R6, R7)
    for (int n = 0; n < ROWS; n++)
      load_row(n, ((n*7) % 41) - 20, ((n*7 + 3) % 41) - 20, ((n*7 + 6) % 41) - 20, ((n*7 + 9) % 41) - 20);
    cur_tag = "R1";
    plan_iter();
    begin
      int c0;
      @(negedge clk);
      start = 1'b1;
      c0 = cyc;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      chk(cyc == c0 + 1 + ROWS*(COLS+3), "R6", 64'(cyc), 64'(c0 + 1 + ROWS*(COLS+3)));
    end
    @(negedge clk);
    chk(!busy, "R6", 64'(busy), 64'd0);

    // iteration 2: previous result as old estimate, random back-pressure,
    // start and load attempts while busy (R7, R5, R8)
    for (int k = 0; k < COLS; k++)
      for (int j = 0; j < COLS; j++) rbb_m[k][j*8 +: 8] = 8'(((k + 2*j) % 9) - 4);
    for (int n = 0; n < ROWS; n++)
      for (int j = 0; j < COLS; j++) rbr_m[n][j*8 +: 8] = 8'(((n + j) % 7) * 5);
    rdy_mode = 1'b1;
    cur_tag = "R7";
    plan_iter();
    pulse_start();
    @(negedge clk);
    start = 1'b1;                       // R8: ignored, must not restart
    ld_en = 1'b1; ld_row = RW'(ROWS-1); ld_data = '1;   // R8: ignored
    @(negedge clk);
    start = 1'b0; ld_en = 1'b0;
    wait_done();
    @(negedge clk);
    chk(exp_d.size() == 0 && !busy, "R8", 64'(exp_d.size()), 64'd0);

    // iteration 3: full-scale operands overflow the accumulator (R3)
    for (int k = 0; k < COLS; k++) rbb_m[k] = {COLS{8'sd127}};
    for (int n = 0; n < ROWS; n++) rbr_m[n] = '0;
    load_row(0, 127, 127, 127, 127);
    load_row(1, -128, -128, -128, -128);
    load_row(2, 127, -128, 90, -77);
    cur_tag = "R3";
    plan_iter();
    pulse_start();
    wait_done();

    // iteration 4: scaled identity drives both rails without wrap (R2)
    rdy_mode = 1'b0;
    for (int k = 0; k < COLS; k++)
      for (int j = 0; j < COLS; j++) rbb_m[k][j*8 +: 8] = (k == j) ? 8'sd127 : 8'sd0;
    load_row(0, -100, -100, 100, 100);
    load_row(1, 100, -100, 3, -3);
    load_row(2, -128, 127, 0, 50);
    cur_tag = "R2";
    plan_iter();
    pulse_start();
    wait_done();
    repeat (3) @(negedge clk);
    chk(!busy && !out_valid, "R10", {62'd0, busy, out_valid}, 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule